// File: doc/BRIEF.md
# Timer Status Flag Register

This block holds the sixteen-bit event status word of a small general-purpose timer with two capture/compare channels. Single-cycle strobes from the surrounding timer logic raise individual sticky flags: counter update, capture/compare per channel, COM (control bits updated), trigger, break and overcapture per channel. Software reads the word through a plain read port and clears flags through a plain write port. Writing a 0 to a flag bit clears that flag, and writing a 1 leaves it unchanged. This lets one flag be cleared without racing the others.

Some of the qualification is done inside the block. It finds the trigger edge on the trigger input, detects overcapture from a capture that arrives while the capture flag is still pending, and holds the break flag while the break input stays active. A per-bit enable vector is ANDed with the flags, and the results are ORed into one level interrupt request.

Top module: `tmr_stat_flags`

## Requirements
- R1: After reset, every flag reads 0 and `irq` is 0.
- R2: Flag positions are: update bit 0, channel-1 capture bit 1, channel-2 capture bit 2, COM bit 5, trigger bit 6, break bit 7, channel-1 overcapture bit 9, channel-2 overcapture bit 10. Bits 3, 4, 8 and 11 to 15 always read 0, even after a write of all ones.
- R3: A write to offset 0x10 clears every flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. A write to any other offset changes nothing.
- R4: A hardware set and a software clear of the same flag in the same cycle leave the flag at 1.
- R5: `upd_evt`, `cap_evt[i]` and `com_evt` each set their flag on the clock edge where they are high. The flag stays set until it is cleared.
- R6: A channel's overcapture flag is set when `cap_evt` arrives while that channel's capture flag is already 1 and `ch_is_input` for that channel is 1. It is never set while `ch_is_input` is 0.
- R7: The break flag is set in every cycle where `brk_active` is 1. A software clear of it takes effect only in a cycle where `brk_active` is 0.
- R8: The trigger flag is set only while `slave_en` is 1. When `gated_mode` is 0, only the active edge of `trg_in` sets it: rising when `trg_fall_act` is 0, falling when it is 1. When `gated_mode` is 1, both edges set it. An edge is judged against the value of `trg_in` one cycle earlier, and that earlier value is 0 just after reset.
- R9: `irq` is 1 exactly when some flag and its matching `irq_en` bit are both 1.
- R10: `rd_data` shows the flags only when `rd_en` is 1 and `rd_addr` is 0x10. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 16 | Write data (0 clears, 1 keeps) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 16 | Read data |
| upd_evt | input | 1 | Counter update strobe |
| cap_evt | input | NUM_CH | Capture/compare strobe per channel |
| ch_is_input | input | NUM_CH | Channel is in input capture mode |
| com_evt | input | 1 | Control bits updated strobe |
| trg_in | input | 1 | Trigger input level |
| trg_fall_act | input | 1 | 1 selects the falling edge as active |
| slave_en | input | 1 | Trigger qualification enabled |
| gated_mode | input | 1 | Both trigger edges count |
| brk_active | input | 1 | Break input is active |
| irq_en | input | 16 | Per-flag interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives strobes and clear-writes into the same cycle. A design that lets the clear win would drop the COM or update event. It clears break while the break input is held, where a design without the gate would read 0 for a cycle. It captures twice in output mode and in input mode, which exposes overcapture detection that ignores the mode or compares against the wrong channel's flag. It walks the trigger input through every edge under each polarity, with gated mode on and off and with qualification disabled. A design that swaps polarity, misses one edge in gated mode or ignores the enable then sets the trigger flag in the wrong cycle. Writes to a neighbouring offset and writes of all ones must leave the word unchanged.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
   localparam int unsigned FLAG_W     = 16;
   localparam int unsigned MAX_CH     = 2;
   localparam int unsigned B_UPD      = 0;
   localparam int unsigned B_CC_BASE  = 1;
   localparam int unsigned B_COM      = 5;
   localparam int unsigned B_TRG      = 6;
   localparam int unsigned B_BRK      = 7;
   localparam int unsigned B_OVC_BASE = 9;

   function automatic logic [FLAG_W-1:0] impl_mask(int unsigned nch);
      logic [FLAG_W-1:0] m;
      m = '0;
      m[B_UPD] = 1'b1;
      m[B_COM] = 1'b1;
      m[B_TRG] = 1'b1;
      m[B_BRK] = 1'b1;
      for (int unsigned i = 0; i < MAX_CH; i++) begin
         if (i < nch) begin
            m[B_CC_BASE+i]  = 1'b1;
            m[B_OVC_BASE+i] = 1'b1;
         end
      end
      return m;
   endfunction
endpackage

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/tmr_trig_qual.sv
module tmr_trig_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic trg_i,
   input  logic fall_act_i,
   input  logic slave_en_i,
   input  logic gated_i,
   output logic evt_o
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= trg_i;
   end

   assign rise = trg_i & ~prev_q;
   assign fall = ~trg_i & prev_q;

   always_comb begin
      if (!slave_en_i)     evt_o = 1'b0;
      else if (gated_i)    evt_o = rise | fall;
      else if (fall_act_i) evt_o = fall;
      else                 evt_o = rise;
   end
endmodule

// File: rtl/tmr_stat_flags.sv
module tmr_stat_flags
   import tmr_stat_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 8,
   parameter int unsigned          NUM_CH     = 2,
   parameter logic [ADDR_W-1:0]    REG_OFFSET = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [FLAG_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [FLAG_W-1:0] rd_data,
   input  logic              upd_evt,
   input  logic [NUM_CH-1:0] cap_evt,
   input  logic [NUM_CH-1:0] ch_is_input,
   input  logic              com_evt,
   input  logic              trg_in,
   input  logic              trg_fall_act,
   input  logic              slave_en,
   input  logic              gated_mode,
   input  logic              brk_active,
   input  logic [FLAG_W-1:0] irq_en,
   output logic              irq
);
   localparam logic [FLAG_W-1:0] IMPL = impl_mask(NUM_CH);

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
      $error("tmr_stat_flags: NUM_CH must be 1..%0d", MAX_CH);
   end
   if (ADDR_W < 1) begin : g_bad_aw
      $error("tmr_stat_flags: ADDR_W must be positive");
   end

   logic              wr_hit;
   logic              trg_set;
   logic [FLAG_W-1:0] flags_q;
   logic [FLAG_W-1:0] set_v;
   logic [FLAG_W-1:0] clr_eff;
   logic              unused_rsv_bits;

   assign wr_hit = wr_en && (wr_addr == REG_OFFSET);

   tmr_trig_qual u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .trg_i      (trg_in),
      .fall_act_i (trg_fall_act),
      .slave_en_i (slave_en),
      .gated_i    (gated_mode),
      .evt_o      (trg_set)
   );

   always_comb begin
      set_v        = '0;
      set_v[B_UPD] = upd_evt;
      set_v[B_COM] = com_evt;
      set_v[B_TRG] = trg_set;
      set_v[B_BRK] = brk_active;
      for (int unsigned i = 0; i < NUM_CH; i++) begin
         set_v[B_CC_BASE+i]  = cap_evt[i];
         set_v[B_OVC_BASE+i] = cap_evt[i] & ch_is_input[i] & flags_q[B_CC_BASE+i];
      end
   end

   always_comb begin
      clr_eff = {FLAG_W{wr_hit}} & ~wr_data;
      if (brk_active) clr_eff[B_BRK] = 1'b0;
   end

   for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      if (IMPL[b]) begin : g_flag
         tmr_flag_bit u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[b]),
            .clr_i  (clr_eff[b]),
            .flag_o (flags_q[b])
         );
      end else begin : g_rsv
         assign flags_q[b] = 1'b0;
      end
   end

   assign unused_rsv_bits = ^{set_v & ~IMPL, clr_eff & ~IMPL};

   assign rd_data = (rd_en && (rd_addr == REG_OFFSET)) ? flags_q : '0;
   assign irq     = |(flags_q & irq_en);
endmodule

// File: rtl/tmr_stat_flags_chk.sv
module tmr_stat_flags_chk
   import tmr_stat_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       NUM_CH     = 2,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [FLAG_W-1:0] wr_data,
   input logic              rd_en,
   input logic [FLAG_W-1:0] rd_data,
   input logic              upd_evt,
   input logic [NUM_CH-1:0] cap_evt,
   input logic [NUM_CH-1:0] ch_is_input,
   input logic              com_evt,
   input logic              slave_en,
   input logic              brk_active,
   input logic [FLAG_W-1:0] irq_en,
   input logic              irq,
   input logic [FLAG_W-1:0] flags
);
   logic hit;
   assign hit = wr_en && (wr_addr == REG_OFFSET);

   AST_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_data[B_UPD] && !upd_evt) |=> !flags[B_UPD]); // R3
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_data[B_COM] && com_evt) |=> flags[B_COM]); // R4
   AST_UPDATE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |=> flags[B_UPD]); // R5
   AST_OVC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[B_OVC_BASE]) |-> $past(cap_evt[0] && ch_is_input[0] && flags[B_CC_BASE])); // R6
   AST_BREAK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      brk_active |=> flags[B_BRK]); // R7
   AST_TRIG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_en |=> !$rose(flags[B_TRG])); // R8
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq); // R9
   AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0)); // R10
endmodule

bind tmr_stat_flags tmr_stat_flags_chk #(
   .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .REG_OFFSET(REG_OFFSET)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .upd_evt(upd_evt), .cap_evt(cap_evt),
   .ch_is_input(ch_is_input), .com_evt(com_evt), .slave_en(slave_en),
   .brk_active(brk_active), .irq_en(irq_en), .irq(irq), .flags(flags_q)
);

// File: tb/tmr_stat_flags_tb.sv
module tmr_stat_flags_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [7:0]  wr_addr;
   logic [15:0] wr_data;
   logic        rd_en;
   logic [7:0]  rd_addr;
   logic [15:0] rd_data;
   logic        upd_evt;
   logic [1:0]  cap_evt;
   logic [1:0]  ch_is_input;
   logic        com_evt;
   logic        trg_in;
   logic        trg_fall_act;
   logic        slave_en;
   logic        gated_mode;
   logic        brk_active;
   logic [15:0] irq_en;
   logic        irq;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string phase = "R1";

   logic [15:0] m;
   logic        m_prev;

   always #(CLK_P/2) clk = ~clk;

   tmr_stat_flags u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .upd_evt(upd_evt),
      .cap_evt(cap_evt), .ch_is_input(ch_is_input), .com_evt(com_evt), .trg_in(trg_in),
      .trg_fall_act(trg_fall_act), .slave_en(slave_en), .gated_mode(gated_mode),
      .brk_active(brk_active), .irq_en(irq_en), .irq(irq)
   );

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rd();
      return (rd_en && rd_addr == 8'h10) ? m : 16'h0;
   endfunction

   task automatic compare();
      chk(phase, rd_data, exp_rd());
      chk({phase, " irq R9"}, {15'd0, irq}, {15'd0, |(m & irq_en)});
   endtask

   // Reference model: one clock step, then compare
   task automatic step();
      logic [15:0] nx;
      logic        tr;
      nx = m;
      if (wr_en && wr_addr == 8'h10) begin
         for (int b = 0; b < 16; b++)
            if (!wr_data[b] && !(b == 7 && brk_active)) nx[b] = 1'b0;
      end
      if (upd_evt) nx[0] = 1'b1;
      for (int i = 0; i < 2; i++) begin
         if (cap_evt[i]) nx[1+i] = 1'b1;
         if (cap_evt[i] && ch_is_input[i] && m[1+i]) nx[9+i] = 1'b1;
      end
      if (com_evt) nx[5] = 1'b1;
      if (brk_active) nx[7] = 1'b1;
      if (!slave_en)      tr = 1'b0;
      else if (gated_mode) tr = (trg_in != m_prev);
      else if (trg_fall_act) tr = (!trg_in && m_prev);
      else                 tr = (trg_in && !m_prev);
      if (tr) nx[6] = 1'b1;
      nx = nx & 16'h06E7;
      @(posedge clk);
      #1;
      m = nx;
      m_prev = trg_in;
      wr_en = 1'b0; upd_evt = 1'b0; cap_evt = 2'b00; com_evt = 1'b0;
      compare();
   endtask

   task automatic wr(logic [7:0] a, logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_en = 1; rd_addr = 8'h10;
      upd_evt = 0; cap_evt = 0; ch_is_input = 0; com_evt = 0; trg_in = 0;
      trg_fall_act = 0; slave_en = 0; gated_mode = 0; brk_active = 0; irq_en = 16'hFFFF;
      m = 0; m_prev = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 reset flags", rd_data, 16'h0000);
      chk("R1 reset irq", {15'd0, irq}, 16'h0000);
      step();

      phase = "R5";
      upd_evt = 1; step();
      chk("R5 update flag", rd_data, 16'h0001);
      cap_evt = 2'b01; step();
      cap_evt = 2'b10; step();
      com_evt = 1; step();
      chk("R5 capture and COM flags", rd_data, 16'h0027);
      step();
      chk("R5 flags stay set", rd_data, 16'h0027);

      phase = "R3";
      wr(8'h14, 16'h0000);
      chk("R3 other offset ignored", rd_data, 16'h0027);
      wr(8'h10, 16'hFFFF);
      chk("R3 write ones keeps", rd_data, 16'h0027);
      wr(8'h10, 16'hFFFD);
      chk("R3 zero clears one bit", rd_data, 16'h0025);
      wr(8'h10, 16'h0000);
      chk("R3 zero clears all", rd_data, 16'h0000);

      phase = "R4";
      com_evt = 1; upd_evt = 1; wr(8'h10, 16'h0000);
      chk("R4 set beats clear", rd_data, 16'h0021);
      wr(8'h10, 16'h0000);

      phase = "R6";
      ch_is_input = 2'b01;
      cap_evt = 2'b11; step();
      chk("R6 first capture no overcapture", rd_data, 16'h0006);
      cap_evt = 2'b11; step();
      chk("R6 input ch overcaptures, output ch not", rd_data, 16'h0206);
      ch_is_input = 2'b11; cap_evt = 2'b10; wr(8'h10, 16'hFFFB);
      chk("R6 capture while clearing still overcaptures", rd_data, 16'h0606);
      wr(8'h10, 16'h0000);

      phase = "R7";
      brk_active = 1; step();
      chk("R7 break sets", rd_data, 16'h0080);
      wr(8'h10, 16'h0000);
      chk("R7 clear blocked while active", rd_data, 16'h0080);
      brk_active = 0; step();
      wr(8'h10, 16'hFF7F);
      chk("R7 clear after release", rd_data, 16'h0000);

      phase = "R8";
      trg_in = 1; step(); trg_in = 0; step();
      chk("R8 disabled no trigger", rd_data, 16'h0000);
      slave_en = 1; trg_fall_act = 0;
      trg_in = 1; step();
      chk("R8 rising active", rd_data, 16'h0040);
      wr(8'h10, 16'h0000);
      trg_in = 0; step();
      chk("R8 falling ignored when rising active", rd_data, 16'h0000);
      trg_fall_act = 1;
      trg_in = 1; step();
      chk("R8 rising ignored when falling active", rd_data, 16'h0000);
      trg_in = 0; step();
      chk("R8 falling active", rd_data, 16'h0040);
      wr(8'h10, 16'h0000);
      gated_mode = 1;
      trg_in = 1; step();
      chk("R8 gated rising", rd_data, 16'h0040);
      wr(8'h10, 16'h0000);
      step();
      chk("R8 gated level no edge", rd_data, 16'h0000);
      trg_in = 0; step();
      chk("R8 gated falling", rd_data, 16'h0040);
      gated_mode = 0; slave_en = 0;

      phase = "R9";
      irq_en = 16'h0001; step();
      chk("R9 masked irq", {15'd0, irq}, 16'h0000);
      irq_en = 16'h0040; step();
      chk("R9 enabled irq", {15'd0, irq}, 16'h0001);
      wr(8'h10, 16'h0000);
      chk("R9 irq drops", {15'd0, irq}, 16'h0000);

      phase = "R2";
      upd_evt = 1; com_evt = 1; cap_evt = 2'b11; brk_active = 1; step();
      cap_evt = 2'b11; brk_active = 0; wr(8'h10, 16'hFFFF);
      chk("R2 reserved read zero", rd_data & 16'hF918, 16'h0000);
      chk("R2 bit layout", rd_data, 16'h06A7);

      phase = "R10";
      rd_en = 0; step();
      chk("R10 no read strobe", rd_data, 16'h0000);
      rd_en = 1; rd_addr = 8'h0C; step();
      chk("R10 wrong read offset", rd_data, 16'h0000);
      rd_addr = 8'h10; step();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule